// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block is a small bank of one-bit ownership flags that two independent ports use to reserve shared resources. The flags are kept apart from any data storage. Each port has its own enable, chip-select, output-enable, read/write strobe, address and data lines. A port asks for a flag by writing 0 on data bit 0 and gives it up by writing 1. A read tells that port whether it currently holds the flag. The returned value is placed on every bit of the read data bus.

Each flag remembers one waiting request for each side. If a port asks for a flag that the other side holds, the request is stored. Ownership then passes to the waiting side on the same clock edge at which the holder releases the flag. When both ports ask for a free flag in the same cycle, the tie is always broken in favour of the left port, and the right port's request is stored as waiting. Read data goes through a register per port. The value captured is the state before the edge, and it holds until that port's next read. Software normally frees every flag by writing 1 from both sides after power-up. In this design a synchronous reset also frees all flags.

Top module: `sem_bank`

## Requirements
- R1: While `rst` is high, all semaphores become free with no waiting requests, and both read data buses become all ones one clock edge later.
- R2: A port accesses the bank only in a cycle with its semaphore enable low (`*_sem_n`=0) and its chip enable high (`*_ce_n`=1). A write outside such a cycle does not change any semaphore.
- R3: The semaphore is selected by address bits [2:0] only. Address bits above bit 2 have no effect.
- R4: A write (`*_we_n`=0) uses data bit 0 only: 0 is a request and 1 is a release. Data bits [7:1] have no effect.
- R5: A request to a free semaphore makes the requesting port its owner. Reads then return 8'h00 to the owner and 8'hFF to the other port.
- R6: A write of 1 from a port that does not own the semaphore leaves ownership unchanged. It only cancels that port's own waiting request.
- R7: When the owner writes 1 and no request is waiting, the semaphore becomes free, and both ports then read 8'hFF.
- R8: A request made while the other port owns the semaphore is stored. On the owner's release edge, ownership passes directly to the waiting port.
- R9: If both ports request the same free semaphore in one cycle, the left port becomes owner and the right request is stored as waiting.
- R10: `*_rdata` is registered. On the clock edge of a read cycle it loads the state as it was before that edge. It holds its value in every cycle that is not a read of that port, including write cycles.
- R11: The eight semaphores are independent. An access to one never changes another.
- R12: A read cycle needs an access cycle with `*_we_n`=1 and `*_oe_n`=0. With `*_oe_n`=1, `*_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left semaphore enable, active low |
| l_ce_n | input | 1 | Left memory chip enable, must be high for semaphore access |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_addr | input | ADDR_W (12) | Left address, bits [2:0] pick the semaphore |
| l_wdata | input | DATA_W (8) | Left write data, bit 0 used |
| l_rdata | output | DATA_W (8) | Left registered read data |
| r_sem_n | input | 1 | Right semaphore enable, active low |
| r_ce_n | input | 1 | Right memory chip enable, must be high for semaphore access |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_addr | input | ADDR_W (12) | Right address, bits [2:0] pick the semaphore |
| r_wdata | input | DATA_W (8) | Right write data, bit 0 used |
| r_rdata | output | DATA_W (8) | Right registered read data |

## Verification
The bench covers several corner cases, and each one catches a specific design error:
- Waiting requests are handed over on release. A design without waiting storage would leave the flag free after the left release, and the right port would read 8'hFF instead of 8'h00.
- A waiting request is cancelled by the waiting side's own release. A design that kept the request would give ownership to the right port, and the left port would never see the flag free.
- Two requests arrive in the same cycle. A design without a fixed priority would award the flag to the wrong side or to neither side.
- A read happens in the same cycle as the other port's release. A design that bypasses the register would return the new owner's value one cycle early.
- Writes arrive with the chip enable low, with upper address bits set, or with upper data bits set. A design that decodes any of these would show a false owner on a later read.

// File: rtl/sem_pkg.sv
package sem_pkg;

    // Default geometry of the bank
    localparam int DEF_NUM_SEM = 8;
    localparam int DEF_ADDR_W  = 12;
    localparam int DEF_DATA_W  = 8;

    // Who holds a semaphore
    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    // Full state of one semaphore
    typedef struct packed {
        owner_e owner;
        logic   wait_l;   // left request waiting on right owner
        logic   wait_r;   // right request waiting on left owner
    } sem_state_t;

    // Decoded operation of one port in one cycle
    typedef struct packed {
        logic wr_req;     // write with bit 0 = 0
        logic wr_rel;     // write with bit 0 = 1
        logic rd;         // read cycle
    } port_op_t;

    localparam sem_state_t SEM_RESET = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

    // Next state of one semaphore, given operations already
    // qualified by the address match.
    function automatic sem_state_t sem_next(sem_state_t cur, port_op_t lop, port_op_t rop);
        sem_state_t nxt;
        logic       keep_r;
        logic       keep_l;
        nxt    = cur;
        keep_r = (cur.wait_r | rop.wr_req) & ~rop.wr_rel;
        keep_l = (cur.wait_l | lop.wr_req) & ~lop.wr_rel;
        case (cur.owner)
            OWN_NONE: begin
                nxt.wait_l = 1'b0;
                nxt.wait_r = 1'b0;
                if (lop.wr_req) begin
                    nxt.owner  = OWN_LEFT;
                    nxt.wait_r = rop.wr_req;   // left wins a tie
                end else if (rop.wr_req) begin
                    nxt.owner = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                nxt.wait_l = 1'b0;
                if (lop.wr_rel) begin
                    nxt.owner  = keep_r ? OWN_RIGHT : OWN_NONE;
                    nxt.wait_r = 1'b0;
                end else begin
                    nxt.wait_r = keep_r;
                end
            end
            OWN_RIGHT: begin
                nxt.wait_r = 1'b0;
                if (rop.wr_rel) begin
                    nxt.owner  = keep_l ? OWN_LEFT : OWN_NONE;
                    nxt.wait_l = 1'b0;
                end else begin
                    nxt.wait_l = keep_l;
                end
            end
            default: nxt = SEM_RESET;
        endcase
        return nxt;
    endfunction

    // Gate a port operation with an address hit
    function automatic port_op_t op_mask(port_op_t op, logic hit);
        port_op_t m;
        m.wr_req = op.wr_req & hit;
        m.wr_rel = op.wr_rel & hit;
        m.rd     = op.rd & hit;
        return m;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int SEL_W  = 3
) (
    input  logic              sem_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel,
    output port_op_t          op
);
    logic access;
    logic unused_bits;

    // Semaphore space only: enable low with memory select high
    assign access = ~sem_n & ce_n;

    always_comb begin
        op.wr_req = access & ~we_n & ~wdata[0];
        op.wr_rel = access & ~we_n &  wdata[0];
        op.rd     = access &  we_n & ~oe_n;
    end

    assign sel = addr[SEL_W-1:0];

    // Upper address and data bits play no part in semaphore access
    assign unused_bits = ^{addr[ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_l,
    input  port_op_t         op_l,
    input  logic [SEL_W-1:0] sel_r,
    input  port_op_t         op_r,
    output logic             own_l,
    output logic             own_r,
    output logic             wait_l,
    output logic             wait_r
);
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

    sem_state_t st_q;
    sem_state_t st_d;
    port_op_t   my_l;
    port_op_t   my_r;

    always_comb begin
        my_l = op_mask(op_l, sel_l == MY_SEL);
        my_r = op_mask(op_r, sel_r == MY_SEL);
        st_d = sem_next(st_q, my_l, my_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEM_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign own_l  = (st_q.owner == OWN_LEFT);
    assign own_r  = (st_q.owner == OWN_RIGHT);
    assign wait_l = st_q.wait_l;
    assign wait_r = st_q.wait_r;
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
    import sem_pkg::*;
#(
    parameter int NUM_SEM = DEF_NUM_SEM,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  port_op_t           op,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SEM-1:0] view,     // 0 where this port owns
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '1;
        end else if (op.rd) begin
            rdata_q <= {DATA_W{view[sel]}};
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_SEM = DEF_NUM_SEM,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int DATA_W  = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int SEL_W  = $clog2(NUM_SEM);
    localparam int NPORTS = 2;   // index 0 = left, 1 = right

    logic [NPORTS-1:0] sem_n_a, ce_n_a, oe_n_a, we_n_a;
    logic [ADDR_W-1:0] addr_a  [NPORTS];
    logic [DATA_W-1:0] wdata_a [NPORTS];
    logic [DATA_W-1:0] rdata_a [NPORTS];
    logic [SEL_W-1:0]  sel_a   [NPORTS];
    port_op_t          op_a    [NPORTS];
    logic [NUM_SEM-1:0] view_a [NPORTS];

    logic [NUM_SEM-1:0] own_l_vec, own_r_vec, wait_l_vec, wait_r_vec;

    assign sem_n_a = {r_sem_n, l_sem_n};
    assign ce_n_a  = {r_ce_n,  l_ce_n};
    assign oe_n_a  = {r_oe_n,  l_oe_n};
    assign we_n_a  = {r_we_n,  l_we_n};
    assign addr_a[0]  = l_addr;
    assign addr_a[1]  = r_addr;
    assign wdata_a[0] = l_wdata;
    assign wdata_a[1] = r_wdata;

    assign view_a[0] = ~own_l_vec;
    assign view_a[1] = ~own_r_vec;

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            sem_port_decode #(
                .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
            ) u_dec (
                .sem_n (sem_n_a[p]),
                .ce_n  (ce_n_a[p]),
                .oe_n  (oe_n_a[p]),
                .we_n  (we_n_a[p]),
                .addr  (addr_a[p]),
                .wdata (wdata_a[p]),
                .sel   (sel_a[p]),
                .op    (op_a[p])
            );

            sem_read_port #(
                .NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .SEL_W(SEL_W)
            ) u_rd (
                .clk   (clk),
                .rst   (rst),
                .op    (op_a[p]),
                .sel   (sel_a[p]),
                .view  (view_a[p]),
                .rdata (rdata_a[p])
            );
        end

        for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
            sem_cell #(
                .SEL_W(SEL_W), .IDX(i)
            ) u_cell (
                .clk    (clk),
                .rst    (rst),
                .sel_l  (sel_a[0]),
                .op_l   (op_a[0]),
                .sel_r  (sel_a[1]),
                .op_r   (op_a[1]),
                .own_l  (own_l_vec[i]),
                .own_r  (own_r_vec[i]),
                .wait_l (wait_l_vec[i]),
                .wait_r (wait_r_vec[i])
            );
        end
    endgenerate

    assign l_rdata = rdata_a[0];
    assign r_rdata = rdata_a[1];
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               l_sem_n,
    input logic               l_ce_n,
    input logic               l_oe_n,
    input logic               l_we_n,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sem_n,
    input logic               r_ce_n,
    input logic               r_oe_n,
    input logic               r_we_n,
    input logic [ADDR_W-1:0]  r_addr,
    input logic [DATA_W-1:0]  r_wdata,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r,
    input logic [NUM_SEM-1:0] wait_l,
    input logic [NUM_SEM-1:0] wait_r
);
    localparam int SEL_W = $clog2(NUM_SEM);

    logic l_read, r_read;
    assign l_read = ~l_sem_n & l_ce_n & l_we_n & ~l_oe_n;
    assign r_read = ~r_sem_n & r_ce_n & r_we_n & ~r_oe_n;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (own_l == '0 && own_r == '0 && wait_l == '0 && wait_r == '0
                 && l_rdata == '1 && r_rdata == '1));

    // R5
    rdata_replicated_chk: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    // R12
    l_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !l_read |=> $stable(l_rdata));

    // R12
    r_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !r_read |=> $stable(r_rdata));

    generate
        for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
            logic l_rel_i, r_rel_i;
            assign l_rel_i = ~l_sem_n & l_ce_n & ~l_we_n & l_wdata[0]
                             & (l_addr[SEL_W-1:0] == SEL_W'(i));
            assign r_rel_i = ~r_sem_n & r_ce_n & ~r_we_n & r_wdata[0]
                             & (r_addr[SEL_W-1:0] == SEL_W'(i));

            // R8
            wait_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
                (!wait_r[i] || own_l[i]) && (!wait_l[i] || own_r[i]));

            // R8
            l_handover_chk: assert property (@(posedge clk) disable iff (rst)
                (own_l[i] && wait_r[i]) |=> (own_l[i] || own_r[i]));

            // R8
            r_handover_chk: assert property (@(posedge clk) disable iff (rst)
                (own_r[i] && wait_l[i]) |=> (own_r[i] || own_l[i]));

            // R6
            l_owner_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (own_l[i] && !l_rel_i) |=> own_l[i]);

            // R6
            r_owner_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (own_r[i] && !r_rel_i) |=> own_r[i]);
        end
    endgenerate
endmodule

bind sem_bank sem_bank_chk #(
    .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .own_l(own_l_vec), .own_r(own_r_vec),
    .wait_l(wait_l_vec), .wait_r(wait_r_vec)
);

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        l_sem_n, l_ce_n, l_oe_n, l_we_n;
    logic [11:0] l_addr;
    logic [7:0]  l_wdata, l_rdata;
    logic        r_sem_n, r_ce_n, r_oe_n, r_we_n;
    logic [11:0] r_addr;
    logic [7:0]  r_wdata, r_rdata;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    sem_bank u_sem_bank (
        .clk(clk), .rst(rst),
        .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        l_sem_n = 1; l_ce_n = 1; l_oe_n = 1; l_we_n = 1; l_addr = '0; l_wdata = '0;
        r_sem_n = 1; r_ce_n = 1; r_oe_n = 1; r_we_n = 1; r_addr = '0; r_wdata = '0;
    endtask

    task automatic drv_wr(input bit right, input int idx, input logic [7:0] d,
                          input logic [8:0] hi = '0);
        if (!right) begin
            l_sem_n = 0; l_ce_n = 1; l_oe_n = 1; l_we_n = 0;
            l_addr = {hi, 3'(idx)}; l_wdata = d;
        end else begin
            r_sem_n = 0; r_ce_n = 1; r_oe_n = 1; r_we_n = 0;
            r_addr = {hi, 3'(idx)}; r_wdata = d;
        end
    endtask

    task automatic drv_rd(input bit right, input int idx, input logic [8:0] hi = '0);
        if (!right) begin
            l_sem_n = 0; l_ce_n = 1; l_oe_n = 0; l_we_n = 1; l_addr = {hi, 3'(idx)};
        end else begin
            r_sem_n = 0; r_ce_n = 1; r_oe_n = 0; r_we_n = 1; r_addr = {hi, 3'(idx)};
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idle_all();
    endtask

    task automatic wr(input bit right, input int idx, input logic [7:0] d,
                      input logic [8:0] hi = '0);
        idle_all();
        drv_wr(right, idx, d, hi);
        step();
    endtask

    task automatic rd_chk(input string tag, input bit right, input int idx,
                          input logic [7:0] exp, input logic [8:0] hi = '0);
        idle_all();
        drv_rd(right, idx, hi);
        step();
        check(tag, right ? r_rdata : l_rdata, exp);
    endtask

    task automatic t_reset();
        check("R1 left rdata after reset", l_rdata, 8'hFF);
        check("R1 right rdata after reset", r_rdata, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            rd_chk("R1 left sees free", 0, i, 8'hFF);
            rd_chk("R1 right sees free", 1, i, 8'hFF);
        end
    endtask

    task automatic t_basic_own();
        wr(0, 2, 8'h00, 9'h141);            // upper address bits set
        rd_chk("R5 owner reads 0", 0, 2, 8'h00, 9'h0AA);
        rd_chk("R5 other reads FF", 1, 2, 8'hFF);
        rd_chk("R3 upper addr ignored", 0, 2, 8'h00, 9'h1FF);
        wr(1, 2, 8'h01);                    // non-owner release
        rd_chk("R6 owner kept", 0, 2, 8'h00);
        rd_chk("R6 other still FF", 1, 2, 8'hFF);
        wr(0, 2, 8'h01);
        rd_chk("R7 left free after release", 0, 2, 8'hFF);
        rd_chk("R7 right free after release", 1, 2, 8'hFF);
    endtask

    task automatic t_handover();
        wr(0, 3, 8'h00);
        wr(1, 3, 8'h00);                    // waits
        rd_chk("R8 waiting side reads FF", 1, 3, 8'hFF);
        wr(0, 3, 8'h01);                    // release, hand over
        rd_chk("R8 right owns after handover", 1, 3, 8'h00);
        rd_chk("R8 left sees FF after handover", 0, 3, 8'hFF);
        wr(1, 3, 8'h01);
        rd_chk("R7 free after right release", 0, 3, 8'hFF);
    endtask

    task automatic t_cancel_wait();
        wr(0, 4, 8'h00);
        wr(1, 4, 8'h00);
        wr(1, 4, 8'h01);                    // cancel own waiting request
        wr(0, 4, 8'h01);
        rd_chk("R6 cancelled wait, right not owner", 1, 4, 8'hFF);
        rd_chk("R6 cancelled wait, left sees free", 0, 4, 8'hFF);
        wr(0, 4, 8'h00);
        rd_chk("R6 free again, left can own", 0, 4, 8'h00);
        wr(0, 4, 8'h01);
    endtask

    task automatic t_tie();
        idle_all();
        drv_wr(0, 5, 8'h00);
        drv_wr(1, 5, 8'h00);
        step();
        rd_chk("R9 left wins tie", 0, 5, 8'h00);
        rd_chk("R9 right loses tie", 1, 5, 8'hFF);
        wr(0, 5, 8'h01);
        rd_chk("R9 right waiting then owns", 1, 5, 8'h00);
        wr(1, 5, 8'h01);
        rd_chk("R9 free after", 0, 5, 8'hFF);
    endtask

    task automatic t_gating();
        wr(0, 0, 8'h00);
        rd_chk("R2 setup owner read", 0, 0, 8'h00);
        // read with chip enable low: no access
        idle_all();
        l_sem_n = 0; l_ce_n = 0; l_oe_n = 0; l_we_n = 1; l_addr = 12'd6;
        step();
        check("R2 read with ce_n low holds", l_rdata, 8'h00);
        // read with output enable high: no read
        idle_all();
        l_sem_n = 0; l_ce_n = 1; l_oe_n = 1; l_we_n = 1; l_addr = 12'd6;
        step();
        check("R12 oe_n high holds rdata", l_rdata, 8'h00);
        // write with chip enable low
        idle_all();
        l_sem_n = 0; l_ce_n = 0; l_oe_n = 1; l_we_n = 0; l_addr = 12'd6; l_wdata = 8'h00;
        step();
        // write with semaphore enable high
        idle_all();
        r_sem_n = 1; r_ce_n = 1; r_we_n = 0; r_addr = 12'd6; r_wdata = 8'h00;
        step();
        rd_chk("R2 gated writes left sem free (left)", 0, 6, 8'hFF);
        rd_chk("R2 gated writes left sem free (right)", 1, 6, 8'hFF);
        wr(0, 0, 8'h01);
    endtask

    task automatic t_data_bits();
        wr(0, 7, 8'hFE);
        rd_chk("R4 bit0=0 requests despite upper bits", 0, 7, 8'h00);
        wr(0, 7, 8'h01);
        rd_chk("R4 bit0=1 releases", 0, 7, 8'hFF);
        wr(1, 7, 8'hAA);                    // bit0 = 0
        rd_chk("R4 right 8'hAA requests", 1, 7, 8'h00);
        wr(1, 7, 8'h55);                    // bit0 = 1
        rd_chk("R4 right 8'h55 releases", 0, 7, 8'hFF);
    endtask

    task automatic t_read_reg();
        wr(1, 1, 8'h00);
        wr(0, 1, 8'h00);                    // left waits
        idle_all();
        drv_wr(1, 1, 8'h01);                // right releases
        drv_rd(0, 1);                       // left reads same cycle
        step();
        check("R10 read captures pre-edge state", l_rdata, 8'hFF);
        rd_chk("R10 next read sees new owner", 0, 1, 8'h00);
        step();
        check("R10 idle cycle holds", l_rdata, 8'h00);
        wr(0, 1, 8'h01);
        check("R10 write cycle holds", l_rdata, 8'h00);
        rd_chk("R10 read after release", 0, 1, 8'hFF);
    endtask

    task automatic t_independent();
        wr(0, 0, 8'h00);
        wr(1, 7, 8'h00);
        rd_chk("R11 left reads sem7 not own", 0, 7, 8'hFF);
        rd_chk("R11 right reads sem0 not own", 1, 0, 8'hFF);
        rd_chk("R11 left owns sem0", 0, 0, 8'h00);
        rd_chk("R11 right owns sem7", 1, 7, 8'h00);
        for (int i = 1; i < 7; i++) rd_chk("R11 others untouched", 0, i, 8'hFF);
        wr(0, 0, 8'h01);
        wr(1, 7, 8'h01);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_all();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 left rdata in reset", l_rdata, 8'hFF);
        check("R1 right rdata in reset", r_rdata, 8'hFF);
        rst = 0;
        t_reset();
        t_basic_own();
        t_handover();
        t_cancel_wait();
        t_tie();
        t_gating();
        t_data_bits();
        t_read_reg();
        t_independent();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule